// File: doc/BRIEF.md
# Adaptive Line Compression Allocation Predictor

This block decides whether a cache should store newly filled lines in compressed or in uncompressed form. The cache reports every access to it: the depth of the referenced tag in the replacement stack of its set, whether the access hit, whether the referenced line is stored compressed, whether a matching tag exists for a line whose data has been dropped, and the running total of compressed sizes, in segments, of all tags from the top of the stack down to the referenced one.

From these inputs the block sorts each access into one of five outcomes. A hit that the set would also have served without compression (stack depth within the uncompressed associativity) is free on an uncompressed line. On a compressed line it is a slowed hit, which is a cost. A hit deeper than the uncompressed associativity is a miss that compression saved, which is a benefit. A miss whose tag is still present is one that compression could have saved when the compressed sizes up to that depth fit into the set's data space, which is also a benefit. Every other miss has no effect.

A single signed saturating counter collects the result. A benefit adds the memory latency, a cost subtracts the decompression latency, and an optional normalized mode adds the latency ratio and subtracts one instead. The registered allocation decision asks for compressed fills while the counter is zero or positive.

Top module: `cmpr_alloc_predictor`

## Requirements
- R1: After reset the counter is 0, alloc_cmp_o is 1 (compress), and outcome_o is 0 (idle).
- R2: An access with acc_valid=1, acc_hit=1, a 1-based acc_pos no greater than ASSOC_UNC (2) and acc_line_cmp=0 gives outcome_o=1 and leaves the counter unchanged.
- R3: A hit with acc_pos no greater than ASSOC_UNC and acc_line_cmp=1 gives outcome_o=2 and subtracts DECOMP_LAT (5) from the counter.
- R4: A hit with acc_pos greater than ASSOC_UNC gives outcome_o=3 and adds MEM_LAT (400), whatever acc_line_cmp is.
- R5: A miss with acc_tag_found=1 and acc_seg_sum no greater than SEG_TOTAL (16) gives outcome_o=4 and adds MEM_LAT. With acc_seg_sum above SEG_TOTAL it gives outcome_o=5 and leaves the counter unchanged.
- R6: A miss with acc_tag_found=0 gives outcome_o=5 and leaves the counter unchanged.
- R7: The 19-bit counter saturates at +262143 and at -262144 and never wraps.
- R8: alloc_cmp_o is 1 when the counter is greater than or equal to 0 and 0 when it is negative. It changes on the same clock edge as the counter, one cycle after the access is presented.
- R9: A cycle with acc_valid=0 gives outcome_o=0 and leaves the counter unchanged.
- R10: With NORMALIZE=1 a benefit adds MEM_LAT/DECOMP_LAT (80) and a cost subtracts 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache access is presented this cycle |
| acc_hit | input | 1 | The access hit |
| acc_pos | input | POS_W | 1-based replacement stack depth of the referenced tag |
| acc_line_cmp | input | 1 | The referenced line is stored compressed |
| acc_tag_found | input | 1 | On a miss, a matching tag without data exists |
| acc_seg_sum | input | SUM_W | Sum of compressed sizes in segments down to acc_pos |
| outcome_o | output | 3 | Registered outcome code of the last cycle |
| pred_cnt_o | output | CNT_W | Signed benefit counter |
| alloc_cmp_o | output | 1 | Registered decision: 1 = allocate compressed |

## Verification
A wrong outcome code appears on outcome_o in the cycle after the access, and a wrong step size appears in the same cycle as a counter value that differs from the expected running total. A counter that wraps instead of saturating shows up as a sign flip at the limits, which also inverts alloc_cmp_o at once. A decision that is off by one around zero can only be seen when the counter lands exactly on 0, so the bench drives it to that value.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        OC_IDLE         = 3'd0,
        OC_PLAIN_HIT    = 3'd1,
        OC_SLOW_HIT     = 3'd2,
        OC_SAVED_MISS   = 3'd3,
        OC_RESCUE_MISS  = 3'd4,
        OC_LOST_MISS    = 3'd5
    } outcome_e;

    function automatic logic is_gain(outcome_e oc);
        return (oc == OC_SAVED_MISS) || (oc == OC_RESCUE_MISS);
    endfunction

    function automatic logic is_loss(outcome_e oc);
        return oc == OC_SLOW_HIT;
    endfunction

endpackage

// File: rtl/cap_classify.sv
module cap_classify
    import cap_pkg::*;
#(
    parameter int POS_W     = 3,
    parameter int SUM_W     = 6,
    parameter int ASSOC_UNC = 2,
    parameter int SEG_TOTAL = 16
) (
    input  logic             valid,
    input  logic             hit,
    input  logic [POS_W-1:0] pos,
    input  logic             line_cmp,
    input  logic             tag_found,
    input  logic [SUM_W-1:0] seg_sum,
    output outcome_e         oc
);
    localparam logic [POS_W-1:0] ASSOC_V = POS_W'(ASSOC_UNC);
    localparam logic [SUM_W-1:0] SEG_V   = SUM_W'(SEG_TOTAL);

    logic shallow;
    logic fits;

    always_comb begin
        shallow = (pos <= ASSOC_V);
        fits    = (seg_sum <= SEG_V);
        oc      = OC_IDLE;
        if (valid) begin
            if (hit) begin
                if (!shallow)      oc = OC_SAVED_MISS;
                else if (line_cmp) oc = OC_SLOW_HIT;
                else               oc = OC_PLAIN_HIT;
            end else begin
                if (tag_found && fits) oc = OC_RESCUE_MISS;
                else                   oc = OC_LOST_MISS;
            end
        end
    end
endmodule

// File: rtl/cap_step.sv
module cap_step
    import cap_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int MEM_LAT    = 400,
    parameter int DECOMP_LAT = 5,
    parameter bit NORMALIZE  = 1'b0
) (
    input  outcome_e           oc,
    output logic signed [CNT_W:0] step
);
    logic signed [CNT_W:0] gain_v;
    logic signed [CNT_W:0] loss_v;

    generate
        if (NORMALIZE) begin : g_norm
            localparam int RATIO = MEM_LAT / DECOMP_LAT;
            assign gain_v = (CNT_W+1)'(RATIO);
            assign loss_v = (CNT_W+1)'(1);
        end else begin : g_raw
            assign gain_v = (CNT_W+1)'(MEM_LAT);
            assign loss_v = (CNT_W+1)'(DECOMP_LAT);
        end
    endgenerate

    always_comb begin
        step = '0;
        if (is_gain(oc))      step = gain_v;
        else if (is_loss(oc)) step = -loss_v;
    end
endmodule

// File: rtl/cap_satadd.sv
module cap_satadd #(
    parameter int CNT_W = 19
) (
    input  logic signed [CNT_W-1:0] cur,
    input  logic signed [CNT_W:0]   step,
    output logic signed [CNT_W-1:0] nxt
);
    localparam int XW = CNT_W + 2;
    localparam logic signed [XW-1:0] HI_V = $signed({3'b000, {(CNT_W-1){1'b1}}});
    localparam logic signed [XW-1:0] LO_V = $signed({3'b111, {(CNT_W-1){1'b0}}});

    logic signed [XW-1:0] wide;

    always_comb begin
        wide = $signed({{2{cur[CNT_W-1]}}, cur}) + $signed({step[CNT_W], step});
        if (wide > HI_V)      nxt = HI_V[CNT_W-1:0];
        else if (wide < LO_V) nxt = LO_V[CNT_W-1:0];
        else                  nxt = wide[CNT_W-1:0];
    end
endmodule

// File: rtl/cmpr_alloc_predictor.sv
module cmpr_alloc_predictor
    import cap_pkg::*;
#(
    parameter int POS_W      = 3,
    parameter int SUM_W      = 6,
    parameter int ASSOC_UNC  = 2,
    parameter int SEG_TOTAL  = 16,
    parameter int CNT_W      = 19,
    parameter int MEM_LAT    = 400,
    parameter int DECOMP_LAT = 5,
    parameter bit NORMALIZE  = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_hit,
    input  logic [POS_W-1:0]        acc_pos,
    input  logic                    acc_line_cmp,
    input  logic                    acc_tag_found,
    input  logic [SUM_W-1:0]        acc_seg_sum,
    output logic [2:0]              outcome_o,
    output logic signed [CNT_W-1:0] pred_cnt_o,
    output logic                    alloc_cmp_o
);
    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
        logic                    alloc;
        outcome_e                oc;
    } state_t;

    state_t st_d, st_q;

    outcome_e                oc_now;
    logic signed [CNT_W:0]   step_now;
    logic signed [CNT_W-1:0] cnt_next;

    cap_classify #(
        .POS_W(POS_W), .SUM_W(SUM_W),
        .ASSOC_UNC(ASSOC_UNC), .SEG_TOTAL(SEG_TOTAL)
    ) u_cls (
        .valid(acc_valid), .hit(acc_hit), .pos(acc_pos),
        .line_cmp(acc_line_cmp), .tag_found(acc_tag_found),
        .seg_sum(acc_seg_sum), .oc(oc_now)
    );

    cap_step #(
        .CNT_W(CNT_W), .MEM_LAT(MEM_LAT),
        .DECOMP_LAT(DECOMP_LAT), .NORMALIZE(NORMALIZE)
    ) u_stp (
        .oc(oc_now), .step(step_now)
    );

    cap_satadd #(.CNT_W(CNT_W)) u_sat (
        .cur(st_q.cnt), .step(step_now), .nxt(cnt_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.oc    = oc_now;
        st_d.cnt   = cnt_next;
        st_d.alloc = ~cnt_next[CNT_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.alloc <= 1'b1;
            st_q.oc    <= OC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign outcome_o   = st_q.oc;
    assign pred_cnt_o  = st_q.cnt;
    assign alloc_cmp_o = st_q.alloc;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int POS_W     = 3,
    parameter int SUM_W     = 6,
    parameter int ASSOC_UNC = 2,
    parameter int SEG_TOTAL = 16,
    parameter int CNT_W     = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    acc_hit,
    input logic [POS_W-1:0]        acc_pos,
    input logic                    acc_line_cmp,
    input logic                    acc_tag_found,
    input logic [SUM_W-1:0]        acc_seg_sum,
    input logic [2:0]              outcome_o,
    input logic signed [CNT_W-1:0] pred_cnt_o,
    input logic                    alloc_cmp_o
);
    localparam logic [POS_W-1:0] ASSOC_V = POS_W'(ASSOC_UNC);

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> outcome_o == 3'd0); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(pred_cnt_o)); // R9

    AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !acc_tag_found) |=> $stable(pred_cnt_o)); // R6

    AST_SLOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && acc_line_cmp && acc_pos <= ASSOC_V)
        |=> (pred_cnt_o <= $past(pred_cnt_o))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && acc_pos > ASSOC_V)
        |=> (pred_cnt_o >= $past(pred_cnt_o))); // R7

    AST_DECISION_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_cmp_o == (pred_cnt_o >= 0)); // R8
endmodule

bind cmpr_alloc_predictor cap_checker #(
    .POS_W(POS_W), .SUM_W(SUM_W), .ASSOC_UNC(ASSOC_UNC),
    .SEG_TOTAL(SEG_TOTAL), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_cmpr_alloc_predictor.sv
module sim_cmpr_alloc_predictor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v = 1'b0, h = 1'b0, c = 1'b0, t = 1'b0;
    logic [2:0] pos = 3'd1;
    logic [5:0] sum = 6'd0;
    logic [2:0] oc0, oc1;
    logic signed [18:0] cnt0, cnt1;
    logic al0, al1;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmpr_alloc_predictor u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(v), .acc_hit(h), .acc_pos(pos),
        .acc_line_cmp(c), .acc_tag_found(t), .acc_seg_sum(sum),
        .outcome_o(oc0), .pred_cnt_o(cnt0), .alloc_cmp_o(al0));

    cmpr_alloc_predictor #(.NORMALIZE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(v), .acc_hit(h), .acc_pos(pos),
        .acc_line_cmp(c), .acc_tag_found(t), .acc_seg_sum(sum),
        .outcome_o(oc1), .pred_cnt_o(cnt1), .alloc_cmp_o(al1));

    typedef struct packed {
        logic       v, h;
        logic [2:0] pos;
        logic       c, t;
        logic [5:0] sum;
        logic [2:0] oc;
        int         cnt;
        logic       al;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 6'd0,  3'd1, 0,    1'b1}, // R2
        '{1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 6'd0,  3'd2, -5,   1'b0}, // R3 R8
        '{1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 6'd0,  3'd3, 395,  1'b1}, // R4
        '{1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 6'd15, 3'd4, 795,  1'b1}, // R5
        '{1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 6'd16, 3'd4, 1195, 1'b1}, // R5 edge
        '{1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 6'd17, 3'd5, 1195, 1'b1}, // R5 over
        '{1'b1, 1'b0, 3'd5, 1'b0, 1'b0, 6'd3,  3'd5, 1195, 1'b1}, // R6
        '{1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 6'd0,  3'd2, 1190, 1'b1}, // R3
        '{1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 6'd0,  3'd1, 1190, 1'b1}, // R2
        '{1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 6'd0,  3'd0, 1190, 1'b1}, // R9
        '{1'b1, 1'b1, 3'd4, 1'b0, 1'b1, 6'd0,  3'd3, 1590, 1'b1}  // R4
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic vv, logic hh, logic [2:0] pp, logic cc, logic tt, logic [5:0] ss);
        v = vv; h = hh; pos = pp; c = cc; t = tt; sum = ss;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 6'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 count", int'(cnt0), 0);
        chk("R1 alloc", int'(al0), 1);
        chk("R1 outcome", int'(oc0), 0);

        foreach (VEC[i]) begin
            drive(VEC[i].v, VEC[i].h, VEC[i].pos, VEC[i].c, VEC[i].t, VEC[i].sum);
            @(negedge clk);
            chk("R2-R6 vector outcome", int'(oc0), int'(VEC[i].oc));
            chk("R2-R6 vector count", int'(cnt0), VEC[i].cnt);
            chk("R8 vector alloc", int'(al0), int'(VEC[i].al));
        end

        // R8: drain exactly to zero, decision stays compress
        drive(1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 6'd0);
        repeat (318) @(negedge clk);
        chk("R8 zero count", int'(cnt0), 0);
        chk("R8 zero alloc", int'(al0), 1);
        @(negedge clk);
        chk("R8 negative count", int'(cnt0), -5);
        chk("R8 negative alloc", int'(al0), 0);

        // R7: low saturation
        repeat (52500) @(negedge clk);
        chk("R7 low limit", int'(cnt0), -262144);
        chk("R7 low alloc", int'(al0), 0);

        // R7: high saturation
        drive(1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 6'd0);
        repeat (1400) @(negedge clk);
        chk("R7 high limit", int'(cnt0), 262143);
        chk("R7 high alloc", int'(al0), 1);
        drive(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 6'd0);
        @(negedge clk);
        chk("R9 hold at limit", int'(cnt0), 262143);

        // R1: reset in mid-run
        do_reset();
        chk("R1 rerun count", int'(cnt0), 0);
        chk("R1 rerun outcome", int'(oc0), 0);
        chk("R10 reset count", int'(cnt1), 0);

        // R10: normalized steps
        drive(1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 6'd0);
        @(negedge clk);
        chk("R10 cost", int'(cnt1), -1);
        chk("R10 alloc", int'(al1), 0);
        drive(1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 6'd8);
        @(negedge clk);
        chk("R10 benefit", int'(cnt1), 79);
        chk("R5 raw beside R10", int'(cnt0), 395);
        drive(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 6'd0);
        @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule